// File: doc/BRIEF.md
# SPI-Commanded Byte Queue Controller

This block is a byte queue with a capacity of 99 entries. An SPI master reaches it through a slave port that works in mode 0. In every transaction, while chip select is low, the master sends one opcode byte and then further bytes. The controller returns a status byte for the opcode, then it stores incoming bytes, hands back stored bytes, or reports how many items the queue holds. The current item count also goes to an output port, so that a display can show it.

SCLK, MOSI and chip select each pass through two synchroniser flops into the system clock. Edges are detected in that domain, so the system clock must run at least 8 times faster than SCLK. Bits travel MSB first. A reply is prepared at the end of a byte exchange and leaves the block during the exchange that follows it. During the opcode exchange MISO shifts out 0x00.

The state machine has six states:
- `S_OPCODE` waits for the opcode.
- `S_CNT_REPLY` waits while the status byte of a count command goes out.
- `S_WRITE_DATA` stores data bytes.
- `S_READ_DATA` waits for a queued byte to finish shifting out.
- `S_READ_FETCH` loads the next queued byte, or 0xFE.
- `S_DISCARD` ignores the rest of the transaction.

The transitions are:
- `S_OPCODE` goes to `S_CNT_REPLY`, `S_WRITE_DATA`, `S_READ_DATA` or `S_DISCARD`, according to the opcode.
- `S_CNT_REPLY` goes to `S_DISCARD` once the status byte has gone out.
- `S_READ_DATA` goes to `S_READ_FETCH` after every byte.
- `S_READ_FETCH` goes back to `S_READ_DATA` one cycle later.
- Every state returns to `S_OPCODE` when chip select goes high.

Top module: `spi_byte_fifo`

## Requirements
- R1: The port works in SPI mode 0 with MSB first. MISO carries 0x00 during the opcode exchange. The reply to each byte exchange goes out on the exchange that follows it.
- R2: Opcodes 0xF0 (count), 0xF1 (write) and 0xF2 (read) are answered with a status byte. The status is 0xFE if the queue is empty, 0xFF if it is full, and 0xFA otherwise.
- R3: After the status of a count command, the next exchange returns the item count as unsigned binary. Later exchanges in that transaction return 0x00.
- R4: During a write, each data byte is stored. Its reply is 0xFA, or 0xFF if the byte just stored made the queue full.
- R5: A write byte that arrives while the queue is full gets the reply 0xFB. It is dropped, and the stored contents stay unchanged.
- R6: During a read, each exchange after the status returns the oldest stored byte. The byte is removed once its exchange completes.
- R7: A read exchange made while the queue is empty returns 0xFE and removes nothing.
- R8: Any other opcode is answered with 0xFB. The bytes that follow in that transaction return 0x00 and change nothing.
- R9: Raising chip select ends the transaction, even mid-byte. A partial byte has no effect, and a queued byte that has not fully shifted out is not removed. The next transaction starts with an opcode.
- R10: After reset, item_count is 0 and MISO is 0. item_count always equals the number of stored bytes and never exceeds 99.
- R11: All 99 entries can be filled and drained in first-in first-out order across the wrap of the non-power-of-two storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from master |
| miso | output | 1 | Serial data to master |
| item_count | output | 7 | Number of bytes currently stored |

## Verification
The bench tries the queue with several patterns:
- **Writes into an empty queue** separate the empty status from the plain acknowledge.
- **A fill run past capacity** tells the "now full" reply apart from a refusal. The bytes drained afterwards show that refused bytes never entered the queue.
- **Partial reads** followed by a full drain, with the pointers moved away from zero first, expose ordering errors at the pointer wrap. They also expose off-by-one removal when a read transaction ends.
- **An unknown opcode** and **transactions cut mid-byte** show that no stray push or pop leaks out of an aborted or ignored exchange.

// File: rtl/spi_byte_fifo_pkg.sv
package spi_byte_fifo_pkg;

    localparam logic [7:0] OP_COUNT = 8'hF0;
    localparam logic [7:0] OP_WRITE = 8'hF1;
    localparam logic [7:0] OP_READ  = 8'hF2;

    localparam logic [7:0] RSP_ACK   = 8'hFA;
    localparam logic [7:0] RSP_NACK  = 8'hFB;
    localparam logic [7:0] RSP_EMPTY = 8'hFE;
    localparam logic [7:0] RSP_FULL  = 8'hFF;
    localparam logic [7:0] RSP_IDLE  = 8'h00;

    typedef enum logic [2:0] {
        S_OPCODE,
        S_CNT_REPLY,
        S_WRITE_DATA,
        S_READ_DATA,
        S_READ_FETCH,
        S_DISCARD
    } ctrl_state_t;

endpackage

// File: rtl/spi_byte_fifo_sync.sv
module spi_byte_fifo_sync #(
    parameter int LINES  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_in,
    input  logic [LINES-1:0] reset_val,
    output logic [LINES-1:0] sync_out,
    output logic [LINES-1:0] sync_prev
);

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain;
            logic              prev;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= {STAGES{reset_val[g]}};
                    prev  <= reset_val[g];
                end else begin
                    chain <= {chain[STAGES-2:0], raw_in[g]};
                    prev  <= chain[STAGES-1];
                end
            end

            assign sync_out[g]  = chain[STAGES-1];
            assign sync_prev[g] = prev;
        end
    endgenerate

endmodule

// File: rtl/spi_byte_fifo_shifter.sv
module spi_byte_fifo_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              mosi_s,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_byte,
    output logic              byte_done,
    output logic [DATA_W-1:0] rx_byte,
    output logic              miso
);

    localparam int BIT_W = $clog2(DATA_W);

    logic [BIT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] rx_sr;
    logic [DATA_W-1:0] tx_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_sr     <= '0;
            tx_sr     <= '0;
            rx_byte   <= '0;
            byte_done <= 1'b0;
        end else if (!cs_act) begin
            bit_cnt   <= '0;
            rx_sr     <= '0;
            tx_sr     <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (sclk_rise) begin
                rx_sr   <= {rx_sr[DATA_W-2:0], mosi_s};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == BIT_W'(DATA_W-1)) begin
                    byte_done <= 1'b1;
                    rx_byte   <= {rx_sr[DATA_W-2:0], mosi_s};
                end
            end
            if (load_en) begin
                tx_sr <= load_byte;
            end else if (sclk_fall && bit_cnt != '0) begin
                tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
            end
        end
    end

    assign miso = tx_sr[DATA_W-1];

    // R1: a reply is loaded only at a byte boundary
    a_r1_load_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> bit_cnt == '0);

    // R1: a completed byte restarts the bit count
    a_r1_done_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> bit_cnt == '0);

endmodule

// File: rtl/spi_byte_fifo_queue.sv
module spi_byte_fifo_queue #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 99
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [DATA_W-1:0]          push_data,
    input  logic                       pop,
    output logic [DATA_W-1:0]          head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       empty,
    output logic                       full
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= next_ptr(wr_ptr);
            if (pop)  rd_ptr <= next_ptr(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assign head  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));

    a_r5_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> count < CNT_W'(DEPTH));

    a_r7_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> count != '0);

    a_r10_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    a_r11_ptrs_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr < PTR_W'(DEPTH)) && (rd_ptr < PTR_W'(DEPTH)));

endmodule

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo
    import spi_byte_fifo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 99,
    parameter int CNT_W  = $clog2(DEPTH+1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             cs_n,
    input  logic             mosi,
    output logic             miso,
    output logic [CNT_W-1:0] item_count
);

    logic [2:0] sync_now, sync_prev;
    logic       sclk_rise, sclk_fall, cs_act, mosi_s;

    spi_byte_fifo_sync #(.LINES(3), .STAGES(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_in    ({cs_n, mosi, sclk}),
        .reset_val (3'b100),
        .sync_out  (sync_now),
        .sync_prev (sync_prev)
    );

    assign sclk_rise = sync_now[0] & ~sync_prev[0];
    assign sclk_fall = ~sync_now[0] & sync_prev[0];
    assign mosi_s    = sync_now[1];
    assign cs_act    = ~sync_now[2];

    logic              byte_done, load_en;
    logic [DATA_W-1:0] rx_byte, load_byte;

    spi_byte_fifo_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .mosi_s    (mosi_s),
        .load_en   (load_en),
        .load_byte (load_byte),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .miso      (miso)
    );

    logic              push, pop, q_empty, q_full;
    logic [DATA_W-1:0] q_head;
    logic [CNT_W-1:0]  q_count;

    spi_byte_fifo_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (rx_byte),
        .pop       (pop),
        .head      (q_head),
        .count     (q_count),
        .empty     (q_empty),
        .full      (q_full)
    );

    assign item_count = q_count;

    ctrl_state_t       state, state_nx;
    logic              in_flight, in_flight_nx;
    logic [DATA_W-1:0] status_byte;

    assign status_byte = q_empty ? RSP_EMPTY : (q_full ? RSP_FULL : RSP_ACK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_OPCODE;
            in_flight <= 1'b0;
        end else begin
            state     <= state_nx;
            in_flight <= in_flight_nx;
        end
    end

    always_comb begin
        state_nx     = state;
        in_flight_nx = in_flight;
        load_en      = 1'b0;
        load_byte    = RSP_IDLE;
        push         = 1'b0;
        pop          = 1'b0;
        if (!cs_act) begin
            state_nx     = S_OPCODE;
            in_flight_nx = 1'b0;
        end else begin
            unique case (state)
                S_OPCODE: if (byte_done) begin
                    load_en = 1'b1;
                    if (rx_byte == OP_COUNT) begin
                        load_byte = status_byte;
                        state_nx  = S_CNT_REPLY;
                    end else if (rx_byte == OP_WRITE) begin
                        load_byte = status_byte;
                        state_nx  = S_WRITE_DATA;
                    end else if (rx_byte == OP_READ) begin
                        load_byte    = status_byte;
                        in_flight_nx = 1'b0;
                        state_nx     = S_READ_DATA;
                    end else begin
                        load_byte = RSP_NACK;
                        state_nx  = S_DISCARD;
                    end
                end
                S_CNT_REPLY: if (byte_done) begin
                    load_en   = 1'b1;
                    load_byte = DATA_W'(q_count);
                    state_nx  = S_DISCARD;
                end
                S_WRITE_DATA: if (byte_done) begin
                    load_en = 1'b1;
                    if (q_full) begin
                        load_byte = RSP_NACK;
                    end else begin
                        push      = 1'b1;
                        load_byte = (q_count == CNT_W'(DEPTH-1)) ? RSP_FULL : RSP_ACK;
                    end
                end
                S_READ_DATA: if (byte_done) begin
                    pop          = in_flight;
                    in_flight_nx = 1'b0;
                    state_nx     = S_READ_FETCH;
                end
                S_READ_FETCH: begin
                    load_en = 1'b1;
                    if (q_empty) begin
                        load_byte = RSP_EMPTY;
                    end else begin
                        load_byte    = q_head;
                        in_flight_nx = 1'b1;
                    end
                    state_nx = S_READ_DATA;
                end
                S_DISCARD: if (byte_done) begin
                    load_en   = 1'b1;
                    load_byte = RSP_IDLE;
                end
                default: state_nx = S_OPCODE;
            endcase
        end
    end

    // R9: chip select released always returns to opcode wait
    a_r9_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> state == S_OPCODE);

    // R6: fetch lasts one cycle and resumes the read loop
    a_r6_fetch_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_READ_FETCH && cs_act) |=> state == S_READ_DATA);

    // R8: a discarded transaction never touches the queue
    a_r8_discard_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DISCARD) |-> !push && !pop);

    // R4: stores happen only in the write state
    a_r4_push_only_writing: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> state == S_WRITE_DATA);

endmodule

// File: tb/spi_byte_fifo_test.sv
`timescale 1ns/1ps
module spi_byte_fifo_test;

    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic       mosi = 1'b0;
    logic       miso;
    logic [6:0] item_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    spi_byte_fifo uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk       (sclk),
        .cs_n       (cs_n),
        .mosi       (mosi),
        .miso       (miso),
        .item_count (item_count)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            wait_clk(HALF);
            rx[i] = miso;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        wait_clk(HALF);
    endtask

    task automatic partial(input logic [7:0] tx, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi = tx[i];
            wait_clk(HALF);
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic cs_begin();
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_end();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(4 * HALF);
    endtask

    task automatic t_reset();
        wait_clk(2);
        check("R10 reset miso", miso, 0);
        check("R10 reset count", item_count, 0);
    endtask

    task automatic t_count(input int exp_status, input int exp_cnt);
        logic [7:0] r;
        cs_begin();
        xfer(8'hF0, r); check("R1 opcode slot idle", r, 8'h00);
        xfer(8'h00, r); check("R2 count status", r, exp_status);
        xfer(8'h00, r); check("R3 count value", r, exp_cnt);
        xfer(8'h00, r); check("R3 after count idle", r, 8'h00);
        cs_end();
    endtask

    task automatic t_read_empty();
        logic [7:0] r;
        cs_begin();
        xfer(8'hF2, r);
        xfer(8'h00, r); check("R2 read status empty", r, 8'hFE);
        xfer(8'h00, r); check("R7 read empty", r, 8'hFE);
        xfer(8'h00, r); check("R7 read empty again", r, 8'hFE);
        cs_end();
        check("R7 count unchanged", item_count, 0);
    endtask

    task automatic t_write_five();
        logic [7:0] r;
        cs_begin();
        xfer(8'hF1, r);
        for (int i = 0; i < 5; i++) begin
            xfer(8'(10 + i), r);
            if (i == 0) check("R2 write status empty", r, 8'hFE);
            else        check("R4 write ack", r, 8'hFA);
        end
        cs_end();
        check("R10 count after writes", item_count, 5);
    endtask

    task automatic t_read_three();
        logic [7:0] r;
        cs_begin();
        xfer(8'hF2, r);
        xfer(8'h00, r); check("R2 read status", r, 8'hFA);
        for (int i = 0; i < 3; i++) begin
            xfer(8'h00, r); check("R6 fifo order", r, 10 + i);
        end
        cs_end();
        check("R6 count after partial read", item_count, 2);
    endtask

    task automatic t_bad_opcode();
        logic [7:0] r;
        cs_begin();
        xfer(8'h55, r);
        xfer(8'hF1, r); check("R8 nack", r, 8'hFB);
        xfer(8'hF2, r); check("R8 ignored", r, 8'h00);
        xfer(8'h33, r); check("R8 ignored", r, 8'h00);
        cs_end();
        check("R8 count unchanged", item_count, 2);
    endtask

    task automatic t_fill();
        logic [7:0] r;
        int exp;
        cs_begin();
        xfer(8'hF1, r);
        for (int j = 0; j < 99; j++) begin
            xfer(8'(100 + j), r);
            if (j == 0)       exp = 8'hFA;
            else if (j < 97)  exp = 8'hFA;
            else if (j == 97) exp = 8'hFF;
            else              exp = 8'hFB;
            if (j == 0)       check("R2 write status", r, exp);
            else if (j < 97)  check("R4 write ack", r, exp);
            else if (j == 97) check("R4 became full", r, exp);
            else              check("R5 refused", r, exp);
        end
        cs_end();
        check("R11 full count", item_count, 99);
    endtask

    task automatic t_drain();
        logic [7:0] r;
        cs_begin();
        xfer(8'hF2, r);
        xfer(8'h00, r); check("R2 read status full", r, 8'hFF);
        for (int k = 0; k < 99; k++) begin
            xfer(8'h00, r);
            check("R11 drain order", r, (k < 2) ? (13 + k) : (100 + k - 2));
        end
        xfer(8'h00, r); check("R5 refused bytes absent", r, 8'hFE);
        xfer(8'h00, r); check("R7 empty after drain", r, 8'hFE);
        cs_end();
        check("R11 count after drain", item_count, 0);
    endtask

    task automatic t_abort();
        logic [7:0] r;
        cs_begin();
        partial(8'hF1, 3);
        cs_end();
        cs_begin();
        xfer(8'hF1, r);
        partial(8'h77, 5);
        cs_end();
        check("R9 partial write dropped", item_count, 0);
        cs_begin();
        xfer(8'hF1, r);
        xfer(8'h21, r);
        xfer(8'h22, r);
        cs_end();
        check("R9 two stored", item_count, 2);
        cs_begin();
        xfer(8'hF2, r);
        xfer(8'h00, r);
        partial(8'h00, 4);
        cs_end();
        check("R9 unfinished read keeps byte", item_count, 2);
        cs_begin();
        xfer(8'hF2, r);
        xfer(8'h00, r); check("R9 fresh opcode status", r, 8'hFA);
        xfer(8'h00, r); check("R9 head intact", r, 8'h21);
        cs_end();
        check("R9 one left", item_count, 1);
    endtask

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        t_reset();
        t_count(8'hFE, 0);
        t_read_empty();
        t_write_five();
        t_count(8'hFA, 5);
        t_read_three();
        t_bad_opcode();
        t_fill();
        t_count(8'hFF, 99);
        t_drain();
        t_abort();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (190000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired got 0 expected 1");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule